// File: doc/BRIEF.md
# Reconfigurable Datapath Row with Windowed Operand Routing

This block is one horizontal stage of a coarse-grained reconfigurable datapath. It has `WIDTH` processing elements. Each element reads its three operands (A, B and C) from the results of the row above. Every element of that row offers two results: its arithmetic result and its forwarded value. An element at column j may only reach the elements in columns j−MCL through j+MCL. A small selector per operand picks one of the 2·(2·MCL+1) sources in that window.

Each element has two units. The arithmetic unit combines A and B using 64-bit integer add, subtract or multiply, or passes A through. The transfer unit forwards C unchanged, so that a value can skip down to a row that is not adjacent. A per-element 64-bit immediate value can stand in for any of the three operands.

All configuration is static input. Both unit outputs are registered, so a row adds exactly one cycle. A valid flag travels alongside the data. Rows are chained by connecting one row's outputs to the next row's previous-row inputs.

Top module: `rdp_row`

## Requirements
- R1: The output valid flag equals the input valid flag of the previous clock cycle. Data presented with the valid flag high appears on the outputs one cycle later.
- R2: While the input valid flag is low, the unit output registers keep their values.
- R3: A synchronous active-high reset clears every unit output to zero and drops the output valid flag.
- R4: Operand selector value s picks window slot k = s>>1, which is previous-row column j−MCL+k. If s[0]=0 the source is that column's arithmetic result; if s[0]=1 it is that column's forwarded value. A selector of 2·MCL therefore takes the arithmetic result of the same column.
- R5: A window slot whose column lies outside 0..WIDTH−1 supplies zero.
- R6: A selector value of 2·(2·MCL+1) or above supplies zero.
- R7: Immediate-enable bit 0 replaces operand A with the element's immediate, bit 1 replaces B, and bit 2 replaces C. The immediate takes precedence over the selector.
- R8: Operation code 00 gives A+B, 01 gives A−B, 10 gives the low 64 bits of A·B, and 11 gives A. All arithmetic wraps modulo 2^64.
- R9: The transfer output of each element is its operand C, without modification.
- R10: Element j uses bits [64j+63:64j] of every data bus, [j·SW+SW−1:j·SW] of each selector bus, [2j+1:2j] of the operation bus, and [3j+2:3j] of the immediate-enable bus. Here SW = clog2(2·(2·MCL+1)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Previous-row data valid |
| prev_fu | input | 64·WIDTH | Previous-row arithmetic results |
| prev_tu | input | 64·WIDTH | Previous-row forwarded values |
| cfg_op | input | 2·WIDTH | Per-element operation code |
| cfg_sel_a | input | SW·WIDTH | Per-element selector for operand A |
| cfg_sel_b | input | SW·WIDTH | Per-element selector for operand B |
| cfg_sel_c | input | SW·WIDTH | Per-element selector for operand C |
| cfg_imm_en | input | 3·WIDTH | Per-element immediate enables (C,B,A) |
| cfg_imm | input | 64·WIDTH | Per-element immediate value |
| out_valid | output | 1 | Output data valid |
| fu_out | output | 64·WIDTH | Registered arithmetic results |
| tu_out | output | 64·WIDTH | Registered forwarded values |

## Verification
The hardest cases to reach are the edge elements, where some window slots lie outside the row. There, a wrong column offset shows up only as a zero where data was expected, or the reverse. The stimulus gives every column distinct data and walks the selectors across all slot values, including the unused codes above the source count. A reference model then predicts which column, which unit or which zero each operand must carry. Randomized configurations mix immediates, invalid selectors and idle cycles. This covers the precedence and hold behaviour alongside the routing.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    localparam int DATA_W = 64;
    localparam int OP_W   = 2;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        FU_ADD   = 2'b00,
        FU_SUB   = 2'b01,
        FU_MUL   = 2'b10,
        FU_PASSA = 2'b11
    } fu_op_e;

    typedef struct packed {
        word_t fu;
        word_t tu;
    } pe_result_t;

    function automatic int sel_width(input int mcl);
        return $clog2(2 * (2 * mcl + 1));
    endfunction

    function automatic word_t fu_calc(input fu_op_e op, input word_t a, input word_t b);
        word_t r;
        case (op)
            FU_ADD:  r = a + b;
            FU_SUB:  r = a - b;
            FU_MUL:  r = a * b;
            default: r = a;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rdp_operand_mux.sv
module rdp_operand_mux
    import rdp_pkg::*;
#(
    parameter int NWIN  = 3,
    parameter int SEL_W = 3
) (
    input  word_t [NWIN-1:0] win_fu,
    input  word_t [NWIN-1:0] win_tu,
    input  logic [SEL_W-1:0] sel,
    input  logic             use_imm,
    input  word_t            imm,
    output word_t            operand
);

    word_t routed;

    always_comb begin
        routed = '0;
        for (int k = 0; k < NWIN; k++) begin
            if (sel == SEL_W'(2 * k))     routed = win_fu[k];
            if (sel == SEL_W'(2 * k + 1)) routed = win_tu[k];
        end
        operand = use_imm ? imm : routed;
    end

endmodule

// File: rtl/rdp_alu.sv
module rdp_alu
    import rdp_pkg::*;
(
    input  fu_op_e op,
    input  word_t  a,
    input  word_t  b,
    output word_t  y
);

    assign y = fu_calc(op, a, b);

endmodule

// File: rtl/rdp_pe.sv
module rdp_pe
    import rdp_pkg::*;
#(
    parameter int MCL   = 1,
    parameter int SEL_W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  word_t [2*MCL:0]       win_fu,
    input  word_t [2*MCL:0]       win_tu,
    input  logic [SEL_W-1:0]      sel_a,
    input  logic [SEL_W-1:0]      sel_b,
    input  logic [SEL_W-1:0]      sel_c,
    input  logic [2:0]            imm_en,
    input  word_t                 imm,
    input  fu_op_e                op,
    output word_t                 fu_q,
    output word_t                 tu_q
);

    localparam int NWIN = 2 * MCL + 1;

    word_t      opnd [3];
    pe_result_t nxt;
    pe_result_t cur;

    logic [SEL_W-1:0] sels [3];
    assign sels[0] = sel_a;
    assign sels[1] = sel_b;
    assign sels[2] = sel_c;

    for (genvar p = 0; p < 3; p++) begin : g_opnd
        rdp_operand_mux #(.NWIN(NWIN), .SEL_W(SEL_W)) u_mux (
            .win_fu  (win_fu),
            .win_tu  (win_tu),
            .sel     (sels[p]),
            .use_imm (imm_en[p]),
            .imm     (imm),
            .operand (opnd[p])
        );
    end

    rdp_alu u_alu (
        .op (op),
        .a  (opnd[0]),
        .b  (opnd[1]),
        .y  (nxt.fu)
    );

    assign nxt.tu = opnd[2];

    always_ff @(posedge clk) begin
        if (rst)           cur <= '0;
        else if (in_valid) cur <= nxt;
    end

    assign fu_q = cur.fu;
    assign tu_q = cur.tu;

endmodule

// File: rtl/rdp_row.sv
module rdp_row
    import rdp_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int MCL   = 1,
    localparam int SEL_W = rdp_pkg::sel_width(MCL),
    localparam int NWIN  = 2 * MCL + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [WIDTH*DATA_W-1:0]   prev_fu,
    input  logic [WIDTH*DATA_W-1:0]   prev_tu,
    input  logic [WIDTH*OP_W-1:0]     cfg_op,
    input  logic [WIDTH*SEL_W-1:0]    cfg_sel_a,
    input  logic [WIDTH*SEL_W-1:0]    cfg_sel_b,
    input  logic [WIDTH*SEL_W-1:0]    cfg_sel_c,
    input  logic [WIDTH*3-1:0]        cfg_imm_en,
    input  logic [WIDTH*DATA_W-1:0]   cfg_imm,
    output logic                      out_valid,
    output logic [WIDTH*DATA_W-1:0]   fu_out,
    output logic [WIDTH*DATA_W-1:0]   tu_out
);

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end

    for (genvar j = 0; j < WIDTH; j++) begin : g_pe
        word_t [NWIN-1:0] win_fu;
        word_t [NWIN-1:0] win_tu;

        for (genvar k = 0; k < NWIN; k++) begin : g_win
            localparam int COL = j - MCL + k;
            if (COL >= 0 && COL < WIDTH) begin : g_in
                assign win_fu[k] = prev_fu[COL*DATA_W +: DATA_W];
                assign win_tu[k] = prev_tu[COL*DATA_W +: DATA_W];
            end else begin : g_out
                assign win_fu[k] = '0;
                assign win_tu[k] = '0;
            end
        end

        rdp_pe #(.MCL(MCL), .SEL_W(SEL_W)) u_pe (
            .clk      (clk),
            .rst      (rst),
            .in_valid (in_valid),
            .win_fu   (win_fu),
            .win_tu   (win_tu),
            .sel_a    (cfg_sel_a[j*SEL_W +: SEL_W]),
            .sel_b    (cfg_sel_b[j*SEL_W +: SEL_W]),
            .sel_c    (cfg_sel_c[j*SEL_W +: SEL_W]),
            .imm_en   (cfg_imm_en[j*3 +: 3]),
            .imm      (cfg_imm[j*DATA_W +: DATA_W]),
            .op       (fu_op_e'(cfg_op[j*OP_W +: OP_W])),
            .fu_q     (fu_out[j*DATA_W +: DATA_W]),
            .tu_q     (tu_out[j*DATA_W +: DATA_W])
        );
    end

endmodule

// File: rtl/rdp_row_chk.sv
module rdp_row_chk
    import rdp_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int MCL   = 1,
    localparam int SEL_W = rdp_pkg::sel_width(MCL),
    localparam int NSRC  = 2 * (2 * MCL + 1)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      in_valid,
    input logic [WIDTH*DATA_W-1:0]   prev_fu,
    input logic [WIDTH*DATA_W-1:0]   prev_tu,
    input logic [WIDTH*OP_W-1:0]     cfg_op,
    input logic [WIDTH*SEL_W-1:0]    cfg_sel_a,
    input logic [WIDTH*SEL_W-1:0]    cfg_sel_b,
    input logic [WIDTH*SEL_W-1:0]    cfg_sel_c,
    input logic [WIDTH*3-1:0]        cfg_imm_en,
    input logic [WIDTH*DATA_W-1:0]   cfg_imm,
    input logic                      out_valid,
    input logic [WIDTH*DATA_W-1:0]   fu_out,
    input logic [WIDTH*DATA_W-1:0]   tu_out
);

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(fu_out) && $stable(tu_out)));

    a_r4_straight_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg_op[1:0] == 2'b11 && !cfg_imm_en[0]
         && cfg_sel_a[SEL_W-1:0] == SEL_W'(2 * MCL))
        |=> fu_out[DATA_W-1:0] == $past(prev_fu[DATA_W-1:0]));

    for (genvar e = 0; e < WIDTH; e++) begin : g_el
        a_r7_imm_on_c: assert property (@(posedge clk) disable iff (rst)
            (in_valid && cfg_imm_en[e*3+2])
            |=> tu_out[e*DATA_W +: DATA_W] == $past(cfg_imm[e*DATA_W +: DATA_W]));

        a_r6_bad_sel_zero: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !cfg_imm_en[e*3+2]
             && int'(cfg_sel_c[e*SEL_W +: SEL_W]) >= NSRC)
            |=> tu_out[e*DATA_W +: DATA_W] == '0);
    end

    if (MCL > 0) begin : g_edge
        a_r5_left_edge_zero: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !cfg_imm_en[2]
             && int'(cfg_sel_c[SEL_W-1:0]) < 2 * MCL)
            |=> tu_out[DATA_W-1:0] == '0);
    end

endmodule

bind rdp_row rdp_row_chk #(.WIDTH(WIDTH), .MCL(MCL)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .prev_fu    (prev_fu),
    .prev_tu    (prev_tu),
    .cfg_op     (cfg_op),
    .cfg_sel_a  (cfg_sel_a),
    .cfg_sel_b  (cfg_sel_b),
    .cfg_sel_c  (cfg_sel_c),
    .cfg_imm_en (cfg_imm_en),
    .cfg_imm    (cfg_imm),
    .out_valid  (out_valid),
    .fu_out     (fu_out),
    .tu_out     (tu_out)
);

// File: tb/rdp_row_test.sv
`timescale 1ns/1ps
module rdp_row_test;

    localparam int W    = 4;
    localparam int M    = 1;
    localparam int SW   = $clog2(2 * (2 * M + 1));
    localparam int NS   = 2 * (2 * M + 1);
    localparam int BUSW = W * 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [BUSW-1:0] prev_fu = '0;
    logic [BUSW-1:0] prev_tu = '0;
    logic [W*2-1:0]  cfg_op = '0;
    logic [W*SW-1:0] cfg_sel_a = '0;
    logic [W*SW-1:0] cfg_sel_b = '0;
    logic [W*SW-1:0] cfg_sel_c = '0;
    logic [W*3-1:0]  cfg_imm_en = '0;
    logic [BUSW-1:0] cfg_imm = '0;
    logic            out_valid;
    logic [BUSW-1:0] fu_out;
    logic [BUSW-1:0] tu_out;

    always #5 clk = ~clk;

    rdp_row #(.WIDTH(W), .MCL(M)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .prev_fu(prev_fu), .prev_tu(prev_tu), .cfg_op(cfg_op),
        .cfg_sel_a(cfg_sel_a), .cfg_sel_b(cfg_sel_b), .cfg_sel_c(cfg_sel_c),
        .cfg_imm_en(cfg_imm_en), .cfg_imm(cfg_imm),
        .out_valid(out_valid), .fu_out(fu_out), .tu_out(tu_out)
    );

    typedef struct {
        logic [BUSW-1:0] fu;
        logic [BUSW-1:0] tu;
        string           tag;
    } exp_t;

    exp_t            sb[$];
    logic [BUSW-1:0] last_fu = '0;
    logic [BUSW-1:0] last_tu = '0;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic check(input string tag, input logic [BUSW-1:0] act, input logic [BUSW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Source choice per R4, R5, R6
    function automatic logic [63:0] pick(input int j, input int s,
                                         input logic [BUSW-1:0] f, input logic [BUSW-1:0] t);
        int col;
        if (s >= NS) return '0;
        col = j - M + s / 2;
        if (col < 0 || col >= W) return '0;
        return (s % 2 == 1) ? t[col*64 +: 64] : f[col*64 +: 64];
    endfunction

    function automatic logic [63:0] calc(input int op, input logic [63:0] a, input logic [63:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a * b;
            default: return a;
        endcase
    endfunction

    task automatic set_elem(input int j, input int op, input int sa, input int sb_, input int sc,
                            input int ie, input logic [63:0] imm);
        cfg_op[j*2 +: 2]      = 2'(op);
        cfg_sel_a[j*SW +: SW] = SW'(sa);
        cfg_sel_b[j*SW +: SW] = SW'(sb_);
        cfg_sel_c[j*SW +: SW] = SW'(sc);
        cfg_imm_en[j*3 +: 3]  = 3'(ie);
        cfg_imm[j*64 +: 64]   = imm;
    endtask

    task automatic set_all(input int op, input int sa, input int sb_, input int sc, input int ie);
        for (int j = 0; j < W; j++) set_elem(j, op, sa, sb_, sc, ie, 64'h1000 + 64'(j));
    endtask

    task automatic drive(input bit v, input logic [BUSW-1:0] f, input logic [BUSW-1:0] t,
                         input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = v;
        prev_fu  = f;
        prev_tu  = t;
        if (v) begin
            for (int j = 0; j < W; j++) begin
                logic [63:0] a, b, c;
                int ie;
                ie = int'(cfg_imm_en[j*3 +: 3]);
                a = (ie & 1) ? cfg_imm[j*64 +: 64] : pick(j, int'(cfg_sel_a[j*SW +: SW]), f, t);
                b = (ie & 2) ? cfg_imm[j*64 +: 64] : pick(j, int'(cfg_sel_b[j*SW +: SW]), f, t);
                c = (ie & 4) ? cfg_imm[j*64 +: 64] : pick(j, int'(cfg_sel_c[j*SW +: SW]), f, t);
                e.fu[j*64 +: 64] = calc(int'(cfg_op[j*2 +: 2]), a, b);
                e.tu[j*64 +: 64] = c;
            end
            e.tag = tag;
            sb.push_back(e);
        end
        @(posedge clk);
        #1;
    endtask

    function automatic logic [BUSW-1:0] pattern(input logic [63:0] base);
        logic [BUSW-1:0] r;
        for (int c = 0; c < W; c++) r[c*64 +: 64] = base + 64'(c) * 64'h101;
        return r;
    endfunction

    // Monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst) begin
                if (out_valid) begin
                    if (sb.size() == 0) begin
                        checks++; fails++;
                        $display("FAIL R1 act=unexpected valid exp=no item");
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check({e.tag, " fu"}, fu_out, e.fu);
                        check({e.tag, " tu"}, tu_out, e.tu);
                        last_fu = e.fu;
                        last_tu = e.tu;
                    end
                end else begin
                    check("R2 hold fu", fu_out, last_fu);
                    check("R2 hold tu", tu_out, last_tu);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [BUSW-1:0] fa, ta;
        repeat (3) @(posedge clk);
        #1;
        check("R3 reset fu", fu_out, '0);
        check("R3 reset tu", tu_out, '0);
        checks++;
        if (out_valid !== 1'b0) begin fails++; $display("FAIL R3 valid act=%b exp=0", out_valid); end
        @(negedge clk);
        rst = 0;

        fa = pattern(64'h0000_0000_0001_0000);
        ta = pattern(64'h0000_0000_0020_0000);

        // R8 add, R4 straight routing, R10 packing
        set_all(0, 2*M, 2*M+1, 2*M, 0);
        drive(1, fa, ta, "R8 add R4 straight R10");
        // R8 subtract with wrap, R4 right-most slot, R5 edges
        set_all(1, 2*(2*M), 2*(2*M)+1, 1, 0);
        drive(1, fa, ta, "R8 sub R5 edge R9");
        set_all(1, 0, 2*M, 2*M+1, 0);
        drive(1, ta, fa, "R8 sub wrap R5 left");
        // R8 multiply low bits
        set_all(2, 2*M, 2*M+1, 2*M, 0);
        drive(1, pattern(64'hFFFF_FFFF_0000_0003), pattern(64'h1_0000_0005), "R8 mul wrap");
        // R8 pass A
        set_all(3, 2*M+1, 0, 2*M, 0);
        drive(1, fa, ta, "R8 passA R1");
        // R2 idle cycles hold values
        drive(0, pattern(64'hDEAD), pattern(64'hBEEF), "R2 idle");
        drive(0, pattern(64'h1234), pattern(64'h5678), "R2 idle");
        // R6 invalid selectors
        set_all(0, NS, (1 << SW) - 1, NS, 0);
        drive(1, fa, ta, "R6 bad sel");
        // R7 immediates on each operand
        set_all(0, 2*M, 2*M, 2*M, 1);
        drive(1, fa, ta, "R7 imm A");
        set_all(1, 2*M, 2*M, 2*M, 2);
        drive(1, fa, ta, "R7 imm B");
        set_all(3, 2*M, 2*M, 0, 4);
        drive(1, fa, ta, "R7 imm C R9");
        // Walk selector through every code on every element
        for (int s = 0; s < (1 << SW); s++) begin
            set_all(3, s, 0, (s + 1) % (1 << SW), 0);
            drive(1, fa, ta, "R4 sweep R5 R6");
        end
        // Randomized mix
        for (int i = 0; i < 60; i++) begin
            logic [BUSW-1:0] rf, rt;
            for (int j = 0; j < W; j++) begin
                set_elem(j, int'($urandom % 4), int'($urandom % (1 << SW)),
                         int'($urandom % (1 << SW)), int'($urandom % (1 << SW)),
                         int'(($urandom % 3 == 0) ? $urandom % 8 : 0),
                         {$urandom, $urandom});
                rf[j*64 +: 64] = {$urandom, $urandom};
                rt[j*64 +: 64] = {$urandom, $urandom};
            end
            drive(($urandom % 4) != 0, rf, rt, "R4 R7 R8 random");
        end
        drive(0, fa, ta, "R2 drain");
        drive(0, fa, ta, "R2 drain");

        // R3: reset mid-stream clears loaded data
        set_all(0, 2*M, 2*M, 2*M, 0);
        drive(1, fa, ta, "R3 before reset");
        @(negedge clk);
        rst = 1;
        in_valid = 0;
        @(posedge clk);
        #1;
        check("R3 mid reset fu", fu_out, '0);
        check("R3 mid reset tu", tu_out, '0);
        checks++;
        if (out_valid !== 1'b0) begin fails++; $display("FAIL R3 valid act=%b exp=0", out_valid); end
        checks++;
        if (sb.size() != 0) begin fails++; $display("FAIL R1 leftover act=%0d exp=0", sb.size()); end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule